// File: doc/BRIEF.md
# DDR Command Decoder and Bank Tracker

This block watches the control pins of a four-bank double-data-rate SDRAM-style device. On every rising clock edge it samples the pins, decodes them into a command, and keeps a record of which banks hold an open row and what that row is. It also follows the power state of the device, which is one of normal, precharge power-down, active power-down or self refresh. It checks each command against the bank and power state and flags any sequence that the device would not accept.

Each decoded command appears one cycle after its sampling edge as a one-hot strobe. The strobe comes with the target bank, the row, column or opcode, the auto-precharge or precharge-all flag, a flag that selects the extended mode register, and an illegal-command pulse.

The burst length is taken from writes to the base mode register. Auto-precharge timing and the check on clock-enable during a burst both use that length.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: When `cs_n` is sampled high, the cycle decodes as no-operation whatever RAS/CAS/WE carry. The strobe `cmd_onehot` is exactly one-hot at all times, and it updates one cycle after the sampling edge. Bit positions: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 auto refresh, 6 self-refresh entry, 7 mode-register write, 8 burst stop.
- R2: With `cs_n` low, the active-low code {ras_n,cas_n,we_n} decodes as follows: 111 no-op, 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode-register write, 110 burst stop. Code 001 with `cke` sampled low is self-refresh entry instead.
- R3: An activate to an idle bank marks that bank open and stores `addr` as its row. `cmd_addr` shows the row, and `cmd_bank` shows the bank. Bank b's row sits at `open_rows[b*13 +: 13]`.
- R4: For a read or write, `cmd_addr` is `addr` with bit 10 cleared, and `cmd_ap` equals `addr[10]`.
- R5: The following raise `illegal` and leave the bank state unchanged: an activate to an open bank, or a read or write to an idle bank.
- R6: A precharge with `addr[10]` high closes every bank. A precharge with `addr[10]` low closes only the bank on `ba`. `cmd_ap` reports `addr[10]`.
- R7: A legal read or write with `addr[10]` high closes its bank on the burst-length-th edge after the command edge.
- R8: A mode-register write with `ba`=01 sets `cmd_ext`. With `ba`=00 it targets the base register, where `addr[2:0]` values 1, 2 and 3 set a burst length of 2, 4 and 8, and other values keep the old length. After reset the burst length is 4. A mode-register write while any bank is open is illegal and changes nothing.
- R9: When `cke` is sampled low in normal mode, the block enters active power-down (`pwr_mode`=2) if any bank is open, or precharge power-down (`pwr_mode`=1) if all banks are idle. `pwr_mode` 0 is normal and 3 is self refresh.
- R10: A power-down state returns to normal when `cke` is sampled high. Commands sampled during power-down or self refresh decode as no-op and do not change any bank.
- R11: Self-refresh entry with all banks idle moves the block to self refresh. Self-refresh exit shows on `pwr_mode` as soon as `cke` rises, without waiting for a clock edge.
- R12: A refresh or self-refresh entry while any bank is open raises `illegal`. The rejected self-refresh entry leads to active power-down.
- R13: Sampling `cke` low while a read or write burst is still running raises `illegal`. A burst stop ends the running burst.
- R14: After reset all banks are idle, the mode is normal, the strobe shows no-op, and `illegal` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write enable command pin |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row, column or opcode address |
| cke | input | 1 | Clock enable |
| cmd_onehot | output | 9 | Decoded command strobe, one-hot |
| cmd_bank | output | 2 | Target bank of the decoded command |
| cmd_addr | output | 13 | Row, column or opcode |
| cmd_ap | output | 1 | Auto-precharge or precharge-all flag |
| cmd_ext | output | 1 | Mode write targets the extended register |
| illegal | output | 1 | Illegal command or sequence pulse |
| bank_open | output | 4 | Per-bank open flag |
| open_rows | output | 52 | Per-bank open row, 13 bits per bank |
| pwr_mode | output | 2 | Power mode: 0 normal, 1 precharge PD, 2 active PD, 3 self refresh |

## Verification
The bench uses the default parameters: four banks, 13-bit rows, a 4-bit burst counter and a reset burst length of 4. With these values, both the reset length and a reprogrammed length of 8 can be run to their end, so the auto-precharge close is checked on the exact edge at both settings. The 4-bit counter holds 8, so a mode write that is rejected while a bank is open can be told apart from one that is accepted. Four banks allow single-bank and all-bank precharge to be compared with two or more banks open at the same time.

// File: rtl/ddr_cmd_pkg.sv
`timescale 1ns/1ps
package ddr_cmd_pkg;

    localparam int NCMD = 9;

    typedef enum logic [3:0] {
        C_NOP = 4'd0,
        C_ACT = 4'd1,
        C_RD  = 4'd2,
        C_WR  = 4'd3,
        C_PRE = 4'd4,
        C_REF = 4'd5,
        C_SRE = 4'd6,
        C_MRS = 4'd7,
        C_BST = 4'd8
    } cmd_e;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'd0,
        PM_PPD    = 2'd1,
        PM_APD    = 2'd2,
        PM_SREF   = 2'd3
    } pmode_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
`timescale 1ns/1ps
module ddr_cmd_decode
    import ddr_cmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    input  logic accept,
    output cmd_e cmd
);

    logic [2:0] code;

    always_comb begin
        code = {ras_n, cas_n, we_n};
        cmd  = C_NOP;
        if (accept && !cs_n) begin
            unique case (code)
                3'b111: cmd = C_NOP;
                3'b011: cmd = C_ACT;
                3'b101: cmd = C_RD;
                3'b100: cmd = C_WR;
                3'b010: cmd = C_PRE;
                3'b001: cmd = cke ? C_REF : C_SRE;
                3'b000: cmd = C_MRS;
                3'b110: cmd = C_BST;
                default: cmd = C_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ddr_bank_tracker.sv
`timescale 1ns/1ps
module ddr_bank_tracker
    import ddr_cmd_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int ROW_W  = 13,
    parameter int BL_W   = 4,
    parameter int AP_BIT = 10,
    localparam int BA_W  = $clog2(NBANK)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  cmd_e                   cmd_i,
    input  logic [BA_W-1:0]        ba_i,
    input  logic [ROW_W-1:0]       addr_i,
    input  logic [BL_W-1:0]        burst_len_i,
    output logic [NBANK-1:0]       open_o,
    output logic [NBANK*ROW_W-1:0] rows_o,
    output logic                   rw_ok_o,
    output logic                   bank_err_o
);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [BL_W-1:0]  ap_left;
    } bank_t;

    bank_t            bank_q [NBANK];
    bank_t            bank_d [NBANK];
    logic [NBANK-1:0] open_vec;
    logic             sel_open;
    logic             is_rw;

    always_comb begin
        sel_open   = open_vec[ba_i];
        is_rw      = (cmd_i == C_RD) || (cmd_i == C_WR);
        rw_ok_o    = is_rw && sel_open;
        bank_err_o = ((cmd_i == C_ACT) && sel_open) || (is_rw && !sel_open);
    end

    for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
        logic hit;
        assign hit          = (ba_i == BA_W'(gb));
        assign open_vec[gb] = bank_q[gb].open;
        assign rows_o[gb*ROW_W +: ROW_W] = bank_q[gb].row;

        always_comb begin
            bank_d[gb] = bank_q[gb];
            if (bank_q[gb].ap_left != '0) begin
                bank_d[gb].ap_left = bank_q[gb].ap_left - 1'b1;
                if (bank_q[gb].ap_left == BL_W'(1)) begin
                    bank_d[gb].open = 1'b0;
                end
            end
            unique case (cmd_i)
                C_ACT: begin
                    if (hit && !bank_q[gb].open) begin
                        bank_d[gb].open = 1'b1;
                        bank_d[gb].row  = addr_i;
                    end
                end
                C_RD, C_WR: begin
                    if (hit && bank_q[gb].open && addr_i[AP_BIT]) begin
                        bank_d[gb].open    = 1'b1;
                        bank_d[gb].ap_left = burst_len_i;
                    end
                end
                C_PRE: begin
                    if (addr_i[AP_BIT] || hit) begin
                        bank_d[gb].open    = 1'b0;
                        bank_d[gb].ap_left = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NBANK; i++) begin
            if (!rst_n) begin
                bank_q[i] <= '0;
            end else begin
                bank_q[i] <= bank_d[i];
            end
        end
    end

    assign open_o = open_vec;

    p_act_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == C_ACT && !open_vec[ba_i]) |=> open_vec[$past(ba_i)]);

    p_bad_rw_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_i == C_RD || cmd_i == C_WR) && !open_vec[ba_i]) |=> !open_vec[$past(ba_i)]);

    p_pre_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == C_PRE && addr_i[AP_BIT]) |=> (open_vec == '0));

endmodule

// File: rtl/ddr_power_ctrl.sv
`timescale 1ns/1ps
module ddr_power_ctrl
    import ddr_cmd_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int BL_W   = 4,
    parameter int DEF_BL = 4,
    localparam int BA_W  = $clog2(NBANK)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cke_i,
    input  cmd_e            cmd_i,
    input  logic            any_open_i,
    input  logic            rw_ok_i,
    input  logic [BA_W-1:0] ba_i,
    input  logic [2:0]      mr_code_i,
    output pmode_e          mode_q_o,
    output pmode_e          pwr_mode_o,
    output logic [BL_W-1:0] burst_len_o,
    output logic            pwr_err_o
);

    typedef struct packed {
        pmode_e          mode;
        logic [BL_W-1:0] bl;
        logic [BL_W-1:0] left;
    } pw_t;

    pw_t  pw_q, pw_d;
    logic err;

    always_comb begin
        pw_d = pw_q;
        err  = 1'b0;
        if (pw_q.left != '0) begin
            pw_d.left = pw_q.left - 1'b1;
        end
        unique case (pw_q.mode)
            PM_NORMAL: begin
                if (rw_ok_i) begin
                    pw_d.left = pw_q.bl;
                end
                if (cmd_i == C_BST) begin
                    pw_d.left = '0;
                end
                if (cmd_i == C_REF && any_open_i) begin
                    err = 1'b1;
                end
                if (cmd_i == C_MRS) begin
                    if (any_open_i) begin
                        err = 1'b1;
                    end else if (ba_i == '0) begin
                        unique case (mr_code_i)
                            3'd1:    pw_d.bl = BL_W'(2);
                            3'd2:    pw_d.bl = BL_W'(4);
                            3'd3:    pw_d.bl = BL_W'(8);
                            default: pw_d.bl = pw_q.bl;
                        endcase
                    end
                end
                if (!cke_i) begin
                    if (pw_q.left != '0) begin
                        err = 1'b1;
                    end
                    if (cmd_i == C_SRE) begin
                        if (any_open_i) begin
                            err       = 1'b1;
                            pw_d.mode = PM_APD;
                        end else begin
                            pw_d.mode = PM_SREF;
                        end
                    end else begin
                        pw_d.mode = any_open_i ? PM_APD : PM_PPD;
                    end
                end
            end
            PM_PPD, PM_APD, PM_SREF: begin
                if (cke_i) begin
                    pw_d.mode = PM_NORMAL;
                end
            end
            default: pw_d.mode = PM_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pw_q.mode <= PM_NORMAL;
            pw_q.bl   <= BL_W'(DEF_BL);
            pw_q.left <= '0;
        end else begin
            pw_q <= pw_d;
        end
    end

    assign mode_q_o    = pw_q.mode;
    assign pwr_mode_o  = (pw_q.mode == PM_SREF && cke_i) ? PM_NORMAL : pw_q.mode;
    assign burst_len_o = pw_q.bl;
    assign pwr_err_o   = err;

    p_pd_type_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_q.mode == PM_NORMAL && !cke_i && cmd_i != C_SRE)
        |=> (pw_q.mode == ($past(any_open_i) ? PM_APD : PM_PPD)));

    p_pd_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((pw_q.mode == PM_PPD || pw_q.mode == PM_APD) && cke_i) |=> (pw_q.mode == PM_NORMAL));

    p_sref_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_q.mode == PM_NORMAL && !cke_i && cmd_i == C_SRE && !any_open_i)
        |=> (pw_q.mode == PM_SREF));

    p_sref_exit_now_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_q.mode == PM_SREF && cke_i) |-> (pwr_mode_o == PM_NORMAL));

endmodule

// File: rtl/ddr_cmd_tracker.sv
`timescale 1ns/1ps
module ddr_cmd_tracker
    import ddr_cmd_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int ROW_W  = 13,
    parameter int BL_W   = 4,
    parameter int DEF_BL = 4,
    parameter int AP_BIT = 10,
    localparam int BA_W  = $clog2(NBANK)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BA_W-1:0]        ba,
    input  logic [ROW_W-1:0]       addr,
    input  logic                   cke,
    output logic [NCMD-1:0]        cmd_onehot,
    output logic [BA_W-1:0]        cmd_bank,
    output logic [ROW_W-1:0]       cmd_addr,
    output logic                   cmd_ap,
    output logic                   cmd_ext,
    output logic                   illegal,
    output logic [NBANK-1:0]       bank_open,
    output logic [NBANK*ROW_W-1:0] open_rows,
    output logic [1:0]             pwr_mode
);

    typedef struct packed {
        logic [NCMD-1:0]  onehot;
        logic [BA_W-1:0]  bank;
        logic [ROW_W-1:0] addr;
        logic             ap;
        logic             ext;
        logic             ill;
    } out_t;

    cmd_e            cmd;
    pmode_e          mode_q;
    pmode_e          mode_out;
    logic [BL_W-1:0] burst_len;
    logic            rw_ok;
    logic            bank_err;
    logic            pwr_err;
    logic            any_open;
    out_t            o_q, o_d;

    ddr_cmd_decode u_decode (
        .cs_n   (cs_n),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .we_n   (we_n),
        .cke    (cke),
        .accept (mode_q == PM_NORMAL),
        .cmd    (cmd)
    );

    ddr_bank_tracker #(
        .NBANK  (NBANK),
        .ROW_W  (ROW_W),
        .BL_W   (BL_W),
        .AP_BIT (AP_BIT)
    ) u_banks (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd),
        .ba_i        (ba),
        .addr_i      (addr),
        .burst_len_i (burst_len),
        .open_o      (bank_open),
        .rows_o      (open_rows),
        .rw_ok_o     (rw_ok),
        .bank_err_o  (bank_err)
    );

    assign any_open = |bank_open;

    ddr_power_ctrl #(
        .NBANK  (NBANK),
        .BL_W   (BL_W),
        .DEF_BL (DEF_BL)
    ) u_power (
        .clk         (clk),
        .rst_n       (rst_n),
        .cke_i       (cke),
        .cmd_i       (cmd),
        .any_open_i  (any_open),
        .rw_ok_i     (rw_ok),
        .ba_i        (ba),
        .mr_code_i   (addr[2:0]),
        .mode_q_o    (mode_q),
        .pwr_mode_o  (mode_out),
        .burst_len_o (burst_len),
        .pwr_err_o   (pwr_err)
    );

    always_comb begin
        o_d             = '0;
        o_d.onehot[cmd] = 1'b1;
        o_d.bank        = ba;
        unique case (cmd)
            C_ACT, C_MRS: o_d.addr = addr;
            C_RD, C_WR:   o_d.addr = addr & ~(ROW_W'(1) << AP_BIT);
            default:      o_d.addr = '0;
        endcase
        o_d.ap  = (cmd == C_RD || cmd == C_WR || cmd == C_PRE) && addr[AP_BIT];
        o_d.ext = (cmd == C_MRS) && (ba == BA_W'(1));
        o_d.ill = bank_err || pwr_err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q        <= '0;
            o_q.onehot <= NCMD'(1);
        end else begin
            o_q <= o_d;
        end
    end

    assign cmd_onehot = o_q.onehot;
    assign cmd_bank   = o_q.bank;
    assign cmd_addr   = o_q.addr;
    assign cmd_ap     = o_q.ap;
    assign cmd_ext    = o_q.ext;
    assign illegal    = o_q.ill;
    assign pwr_mode   = mode_out;

    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmd_onehot) == 1);

    p_deselect_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (cmd_onehot == NCMD'(1)));

    p_pdn_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != PM_NORMAL) |=> (cmd_onehot == NCMD'(1)));

endmodule

// File: tb/ddr_cmd_tracker_bench.sv
`timescale 1ns/1ps
module ddr_cmd_tracker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic        cke = 1'b1;
    logic [8:0]  cmd_onehot;
    logic [1:0]  cmd_bank;
    logic [12:0] cmd_addr;
    logic        cmd_ap, cmd_ext, illegal;
    logic [3:0]  bank_open;
    logic [51:0] open_rows;
    logic [1:0]  pwr_mode;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ddr_cmd_tracker u_ddr_cmd_tracker (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .cke(cke),
        .cmd_onehot(cmd_onehot), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
        .cmd_ap(cmd_ap), .cmd_ext(cmd_ext), .illegal(illegal),
        .bank_open(bank_open), .open_rows(open_rows), .pwr_mode(pwr_mode)
    );

    // {cs_n, ras/cas/we, ba, addr, cke, expected onehot, illegal, bank_open, pwr_mode}
    localparam int NV = 13;
    localparam logic [35:0] VEC [NV] = '{
        {1'b0, 3'b111, 2'd0, 13'h0000, 1'b1, 9'h001, 1'b0, 4'b0000, 2'd0},
        {1'b1, 3'b011, 2'd2, 13'h0000, 1'b1, 9'h001, 1'b0, 4'b0000, 2'd0},
        {1'b0, 3'b011, 2'd1, 13'h0123, 1'b1, 9'h002, 1'b0, 4'b0010, 2'd0},
        {1'b0, 3'b011, 2'd1, 13'h0456, 1'b1, 9'h002, 1'b1, 4'b0010, 2'd0},
        {1'b0, 3'b101, 2'd2, 13'h0000, 1'b1, 9'h004, 1'b1, 4'b0010, 2'd0},
        {1'b0, 3'b011, 2'd3, 13'h0000, 1'b1, 9'h002, 1'b0, 4'b1010, 2'd0},
        {1'b0, 3'b100, 2'd3, 13'h0000, 1'b1, 9'h008, 1'b0, 4'b1010, 2'd0},
        {1'b0, 3'b010, 2'd1, 13'h0000, 1'b1, 9'h010, 1'b0, 4'b1000, 2'd0},
        {1'b0, 3'b001, 2'd0, 13'h0000, 1'b1, 9'h020, 1'b1, 4'b1000, 2'd0},
        {1'b0, 3'b010, 2'd0, 13'h0400, 1'b1, 9'h010, 1'b0, 4'b0000, 2'd0},
        {1'b0, 3'b001, 2'd0, 13'h0000, 1'b1, 9'h020, 1'b0, 4'b0000, 2'd0},
        {1'b0, 3'b000, 2'd1, 13'h0000, 1'b1, 9'h080, 1'b0, 4'b0000, 2'd0},
        {1'b0, 3'b110, 2'd0, 13'h0000, 1'b1, 9'h100, 1'b0, 4'b0000, 2'd0}
    };

    function automatic string vreq(int i);
        case (i)
            1:       return "R1";
            2, 5:    return "R3";
            3, 4:    return "R5";
            6:       return "R4";
            7, 9:    return "R6";
            8:       return "R12";
            11:      return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic cs, input logic [2:0] rcw, input logic [1:0] b,
                        input logic [12:0] a, input logic ck);
        @(negedge clk);
        cs_n = cs; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a; cke = ck;
        @(posedge clk);
        #2;
    endtask

    task automatic nop(input logic ck);
        step(1'b0, 3'b111, 2'd0, 13'h0, ck);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cs_n = 1'b1; cke = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        // R14 reset state
        chk("R14", "onehot", 32'(cmd_onehot), 32'h001);
        chk("R14", "illegal", 32'(illegal), 32'h0);
        chk("R14", "bank_open", 32'(bank_open), 32'h0);
        chk("R14", "pwr_mode", 32'(pwr_mode), 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [35:0] v;
            v = VEC[i];
            step(v[35], v[34:32], v[31:30], v[29:17], v[16]);
            checks++;
            if ({cmd_onehot, illegal, bank_open, pwr_mode} !== v[15:0]) begin
                fails++;
                $display("FAIL %s vector %0d: actual %0h expected %0h", vreq(i), i,
                         {cmd_onehot, illegal, bank_open, pwr_mode}, v[15:0]);
            end
        end

        do_reset();
        // R3 activate fields and stored row
        step(1'b0, 3'b011, 2'd2, 13'h1ABC, 1'b1);
        chk("R3", "cmd_addr", 32'(cmd_addr), 32'h1ABC);
        chk("R3", "cmd_bank", 32'(cmd_bank), 32'h2);
        chk("R3", "open_row", 32'(open_rows[26 +: 13]), 32'h1ABC);
        // R4 read column and auto-precharge flag
        step(1'b0, 3'b101, 2'd2, 13'h0455, 1'b1);
        chk("R4", "cmd_addr", 32'(cmd_addr), 32'h0055);
        chk("R4", "cmd_ap", 32'(cmd_ap), 32'h1);
        // R7 auto-precharge after 4 edges
        repeat (3) nop(1'b1);
        chk("R7", "open before close", 32'(bank_open[2]), 32'h1);
        nop(1'b1);
        chk("R7", "open after close", 32'(bank_open[2]), 32'h0);

        // R8 mode register writes
        step(1'b0, 3'b000, 2'd0, 13'h0003, 1'b1);
        chk("R8", "ext base", 32'(cmd_ext), 32'h0);
        chk("R8", "illegal base", 32'(illegal), 32'h0);
        step(1'b0, 3'b000, 2'd1, 13'h0000, 1'b1);
        chk("R8", "ext extended", 32'(cmd_ext), 32'h1);
        step(1'b0, 3'b011, 2'd0, 13'h0010, 1'b1);
        step(1'b0, 3'b000, 2'd0, 13'h0001, 1'b1);
        chk("R8", "write with open bank", 32'(illegal), 32'h1);
        step(1'b0, 3'b101, 2'd0, 13'h0400, 1'b1);
        repeat (7) nop(1'b1);
        chk("R8", "length 8 still open", 32'(bank_open[0]), 32'h1);
        nop(1'b1);
        chk("R8", "length 8 closed", 32'(bank_open[0]), 32'h0);

        // R13 cke drop during burst, then R10 power-down behaviour
        step(1'b0, 3'b011, 2'd0, 13'h0020, 1'b1);
        step(1'b0, 3'b101, 2'd0, 13'h0000, 1'b1);
        nop(1'b0);
        chk("R13", "illegal cke drop", 32'(illegal), 32'h1);
        chk("R9", "active power-down", 32'(pwr_mode), 32'h2);
        step(1'b0, 3'b010, 2'd0, 13'h0400, 1'b0);
        chk("R10", "ignored cmd strobe", 32'(cmd_onehot), 32'h001);
        chk("R10", "ignored precharge", 32'(bank_open), 32'h1);
        nop(1'b1);
        chk("R10", "exit power-down", 32'(pwr_mode), 32'h0);
        step(1'b0, 3'b110, 2'd0, 13'h0000, 1'b1);
        chk("R13", "burst stop strobe", 32'(cmd_onehot), 32'h100);
        nop(1'b0);
        chk("R13", "no illegal after burst stop", 32'(illegal), 32'h0);
        nop(1'b1);

        // R9 precharge power-down
        step(1'b0, 3'b010, 2'd0, 13'h0400, 1'b1);
        chk("R6", "all closed", 32'(bank_open), 32'h0);
        nop(1'b0);
        chk("R9", "precharge power-down", 32'(pwr_mode), 32'h1);
        chk("R9", "no illegal", 32'(illegal), 32'h0);
        nop(1'b1);

        // R11 self refresh
        step(1'b0, 3'b001, 2'd0, 13'h0000, 1'b0);
        chk("R11", "self-refresh strobe", 32'(cmd_onehot), 32'h040);
        chk("R11", "self refresh mode", 32'(pwr_mode), 32'h3);
        step(1'b0, 3'b011, 2'd0, 13'h0000, 1'b0);
        chk("R10", "ignored in self refresh", 32'(bank_open), 32'h0);
        @(negedge clk);
        cs_n = 1'b1; cke = 1'b1;
        #1;
        chk("R11", "exit before edge", 32'(pwr_mode), 32'h0);
        @(posedge clk);
        #2;
        chk("R11", "exit after edge", 32'(pwr_mode), 32'h0);

        // R12 self-refresh entry with an open bank
        step(1'b0, 3'b011, 2'd3, 13'h0001, 1'b1);
        step(1'b0, 3'b001, 2'd0, 13'h0000, 1'b0);
        chk("R12", "illegal", 32'(illegal), 32'h1);
        chk("R12", "falls to active power-down", 32'(pwr_mode), 32'h2);
        nop(1'b1);
        chk("R10", "normal again", 32'(pwr_mode), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule